// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Bank

This block holds the control and status registers for every channel of a multi-channel descriptor DMA controller. It sits on a 32-bit register bus that uses byte enables. The upper address bits pick the channel and address bits 7:2 pick the register. Each channel stores its descriptor and buffer pointers, a two-bit configuration, a one-bit command register, a ten-bit stream-command register and an interrupt mask.

The data engines send short set pulses for interrupt causes, a start pulse, an end-of-list flag and an eight-bit stream-command source value. From these inputs and the configuration writes, the bank keeps a raw cause vector and a one-hot run state for each channel. It drives a registered interrupt line per channel, which is high whenever any raw cause is also enabled in the mask. Reads return data one cycle after the request. The status register is built from live state when it is read; it is not a stored word.

Top module: `dmac_regbank`

## Requirements
- R1: The channel is address bits [ADDR_W-1:13] and the register is bits 7:2. Pointer registers sit at byte offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C. Each keeps a full 32-bit value, and a read returns it on bus_rdata with bus_rvalid high in the cycle after bus_rd.
- R2: After reset, every pointer, configuration, command, stream-command, mask and raw register is zero, every irq line is low, and the run state is RESET.
- R3: Configuration sits at 0x84, with bit 0 = enable and bit 1 = stop. A write with bit 1 set moves the state to STOPPED (code 2). A write with bit 0 clear moves it to RESET (code 1), and this rule wins over the stop rule. The state code also appears on ch_state.
- R4: A start pulse on eng_go moves the state to RUNNING (code 4), but only if the stored configuration is enable = 1 and stop = 0. A configuration write in the same cycle that clears enable or sets stop overrides the start.
- R5: The status register at 0x88 reads as {16'b0, source[7:0], 2'b0, eol, 2'b0, state[2:0]}. With source = 1 after reset, it reads 0x101.
- R6: Writing the acknowledge register at 0x90 clears each raw cause (0x94) whose bit is set in the written value. The acknowledge register always reads back as zero.
- R7: If an engine set pulse and an acknowledge of the same cause bit arrive in the same cycle, the cause stays set.
- R8: The masked register at 0x98 reads raw AND mask (mask at 0x8C). irq for a channel is high exactly when its masked value is nonzero, and it changes on the same clock edge as the raw or mask register.
- R9: The command register at 0x80 keeps only bit 0, and the stream-command register at 0x9C keeps only bits 9:0. A write to either with any other bit set pulses bus_inval for one cycle, and the low bits are still stored.
- R10: An access with bus_be other than 4'hF pulses bus_err in the next cycle and changes no register. A narrow read returns zero.
- R11: Writes to the raw and masked registers are ignored.
- R12: A write to one channel leaves the registers of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Narrow-access error pulse |
| bus_inval | output | 1 | Out-of-field command write pulse |
| eng_irq_set | input | NUM_CH*IRQ_W | Raw cause set pulses, one field per channel |
| eng_go | input | NUM_CH | Engine start pulses |
| eng_eol | input | NUM_CH | End-of-list flags |
| eng_src | input | NUM_CH*8 | Stream-command source per channel |
| ch_state | output | NUM_CH*3 | One-hot run state per channel |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
If the raw or mask registers are wrong, irq shows it on the edge that follows the faulty update, one cycle before the masked register can be read back. A wrong run state shows on ch_state at once and in the status word one read later. A decode fault, such as a wrong channel slice or a narrow access that still writes, only becomes visible when the affected register is read back. For that reason the tests read the neighbouring channels and the untouched registers as well.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // register word indices (byte offset / 4)
  localparam logic [5:0] RI_DPTR  = 6'd0;
  localparam logic [5:0] RI_SDATA = 6'd22;
  localparam logic [5:0] RI_SBUF  = 6'd23;
  localparam logic [5:0] RI_GRP   = 6'd24;
  localparam logic [5:0] RI_GDOWN = 6'd31;
  localparam logic [5:0] RI_CMD   = 6'd32;
  localparam logic [5:0] RI_CFG   = 6'd33;
  localparam logic [5:0] RI_STAT  = 6'd34;
  localparam logic [5:0] RI_MASK  = 6'd35;
  localparam logic [5:0] RI_ACK   = 6'd36;
  localparam logic [5:0] RI_RAW   = 6'd37;
  localparam logic [5:0] RI_MSKD  = 6'd38;
  localparam logic [5:0] RI_SCMD  = 6'd39;

  // one-hot run state codes
  localparam logic [2:0] ST_RESET = 3'b001;
  localparam logic [2:0] ST_STOP  = 3'b010;
  localparam logic [2:0] ST_RUN   = 3'b100;

  localparam int WIN_BITS = 13;  // 8 KiB per channel
  localparam int SCMD_W   = 10;
endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic [CH_W-1:0]   ch_sel,
  output logic [5:0]        reg_idx,
  output logic              full_word,
  output logic              in_range
);
  import dmac_pkg::*;

  logic [ADDR_W-1:0] ch_field;
  logic              unused_bits;

  always_comb begin
    ch_field  = addr >> WIN_BITS;
    ch_sel    = ch_field[CH_W-1:0];
    in_range  = ch_field < ADDR_W'(NUM_CH);
    reg_idx   = addr[7:2];
    full_word = (be == 4'hF);
  end

  assign unused_bits = ^{addr[1:0]};
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int IRQ_W = 4,
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [5:0]       wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [5:0]       rd_idx,
  output logic [31:0]      rd_data,
  input  logic [IRQ_W-1:0] set_in,
  input  logic             go_in,
  input  logic             eol_in,
  input  logic [SRC_W-1:0] src_in,
  output logic [2:0]       state_o,
  output logic             irq_o,
  output logic             inval_o
);
  import dmac_pkg::*;

  logic [31:0]       p_dptr, p_sdata, p_sbuf, p_grp, p_gdown;
  logic [1:0]        cfg;
  logic              cmd;
  logic [SCMD_W-1:0] scmd;
  logic [IRQ_W-1:0]  mask, raw;
  logic [2:0]        state;
  logic              irq_q;

  logic [IRQ_W-1:0]  ack_v, mask_n, raw_n;
  logic [2:0]        state_n;
  logic              cfg_we;

  always_comb begin
    cfg_we = wr_en && (wr_idx == RI_CFG);
    ack_v  = (wr_en && wr_idx == RI_ACK) ? wr_data[IRQ_W-1:0] : '0;
    mask_n = (wr_en && wr_idx == RI_MASK) ? wr_data[IRQ_W-1:0] : mask;
    raw_n  = (raw & ~ack_v) | set_in;   // set pulses win over acknowledge
    state_n = state;
    if (go_in && cfg == 2'b01) state_n = ST_RUN;
    if (cfg_we) begin
      if (wr_data[1])  state_n = ST_STOP;
      if (!wr_data[0]) state_n = ST_RESET;  // disable has priority
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_dptr <= '0; p_sdata <= '0; p_sbuf <= '0; p_grp <= '0; p_gdown <= '0;
      cfg <= '0; cmd <= 1'b0; scmd <= '0;
      mask <= '0; raw <= '0; state <= ST_RESET; irq_q <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (wr_idx)
          RI_DPTR:  p_dptr  <= wr_data;
          RI_SDATA: p_sdata <= wr_data;
          RI_SBUF:  p_sbuf  <= wr_data;
          RI_GRP:   p_grp   <= wr_data;
          RI_GDOWN: p_gdown <= wr_data;
          RI_CMD:   cmd     <= wr_data[0];
          RI_CFG:   cfg     <= wr_data[1:0];
          RI_SCMD:  scmd    <= wr_data[SCMD_W-1:0];
          default: ;
        endcase
      end
      mask  <= mask_n;
      raw   <= raw_n;
      state <= state_n;
      irq_q <= |(raw_n & mask_n);
    end
  end

  always_comb begin
    inval_o = wr_en && (((wr_idx == RI_CMD) && (wr_data[31:1] != '0)) ||
                        ((wr_idx == RI_SCMD) && (wr_data[31:SCMD_W] != '0)));
    unique case (rd_idx)
      RI_DPTR:  rd_data = p_dptr;
      RI_SDATA: rd_data = p_sdata;
      RI_SBUF:  rd_data = p_sbuf;
      RI_GRP:   rd_data = p_grp;
      RI_GDOWN: rd_data = p_gdown;
      RI_CMD:   rd_data = {31'b0, cmd};
      RI_CFG:   rd_data = {30'b0, cfg};
      RI_STAT:  rd_data = {16'b0, src_in, 2'b0, eol_in, 2'b0, state};
      RI_MASK:  rd_data = 32'(mask);
      RI_RAW:   rd_data = 32'(raw);
      RI_MSKD:  rd_data = 32'(raw & mask);
      RI_SCMD:  rd_data = 32'(scmd);
      default:  rd_data = '0;  // acknowledge and holes read zero
    endcase
  end

  assign state_o = state;
  assign irq_o   = irq_q;

  // R6: acknowledged causes are gone next cycle when nothing re-sets them
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == RI_ACK && set_in == '0) |=>
      ((raw & $past(wr_data[IRQ_W-1:0])) == '0));
  // R7: a set pulse always lands
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (set_in != '0) |=> ((raw & $past(set_in)) == $past(set_in)));
  // R8: line tracks masked causes
  p_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw & mask));
  // R3: disable write forces RESET
  p_cfg_rst_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !wr_data[0]) |=> (state == ST_RESET));
  // R3: state stays one-hot
  p_state_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(state) == 1);
  // R4: start with enable and no stop reaches RUNNING
  p_go_run_r4: assert property (@(posedge clk) disable iff (rst)
    (go_in && cfg == 2'b01 && !cfg_we) |=> (state == ST_RUN));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank #(
  parameter int NUM_CH = 4,
  parameter int IRQ_W  = 4,
  parameter int ADDR_W = 13 + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [3:0]              bus_be,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  output logic                    bus_err,
  output logic                    bus_inval,
  input  logic [NUM_CH*IRQ_W-1:0] eng_irq_set,
  input  logic [NUM_CH-1:0]       eng_go,
  input  logic [NUM_CH-1:0]       eng_eol,
  input  logic [NUM_CH*8-1:0]     eng_src,
  output logic [NUM_CH*3-1:0]     ch_state,
  output logic [NUM_CH-1:0]       irq
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SRC_W = 8;

  logic [CH_W-1:0] ch_sel;
  logic [5:0]      reg_idx;
  logic            full_word, in_range, wr_ok;
  logic [31:0]     ch_rd [NUM_CH];
  logic [NUM_CH-1:0] ch_inval;

  dmac_addr_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) i_dec (
    .addr(bus_addr), .be(bus_be), .ch_sel(ch_sel), .reg_idx(reg_idx),
    .full_word(full_word), .in_range(in_range));

  assign wr_ok = bus_wr && full_word && in_range;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmac_chan #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) i_chan (
      .clk(clk), .rst(rst),
      .wr_en(wr_ok && (ch_sel == CH_W'(g))),
      .wr_idx(reg_idx), .wr_data(bus_wdata),
      .rd_idx(reg_idx), .rd_data(ch_rd[g]),
      .set_in(eng_irq_set[g*IRQ_W +: IRQ_W]),
      .go_in(eng_go[g]), .eol_in(eng_eol[g]),
      .src_in(eng_src[g*SRC_W +: SRC_W]),
      .state_o(ch_state[g*3 +: 3]), .irq_o(irq[g]),
      .inval_o(ch_inval[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0; bus_rvalid <= 1'b0; bus_err <= 1'b0; bus_inval <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_err    <= (bus_wr || bus_rd) && !full_word;
      bus_inval  <= |ch_inval;
      bus_rdata  <= (bus_rd && full_word && in_range) ? ch_rd[ch_sel] : '0;
    end
  end

  // R10: a narrow access reports an error next cycle
  p_narrow_err_r10: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_be != 4'hF) |=> bus_err);
  // R10: a narrow read never returns data
  p_narrow_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_be != 4'hF) |=> (bus_rdata == '0));
  // R1: read data valid follows the request by one cycle
  p_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/test_dmac_regbank.sv
module test_dmac_regbank;
  localparam int NUM_CH = 4;
  localparam int IRQ_W  = 4;
  localparam int ADDR_W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bus_err, bus_inval;
  logic [NUM_CH*IRQ_W-1:0] eng_irq_set = '0;
  logic [NUM_CH-1:0] eng_go = '0, eng_eol = '0;
  logic [NUM_CH*8-1:0] eng_src = {NUM_CH{8'h01}};
  logic [NUM_CH*3-1:0] ch_state;
  logic [NUM_CH-1:0] irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dmac_regbank #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)) i_dmac_regbank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .bus_inval(bus_inval),
    .eng_irq_set(eng_irq_set), .eng_go(eng_go), .eng_eol(eng_eol),
    .eng_src(eng_src), .ch_state(ch_state), .irq(irq));

  function automatic logic [ADDR_W-1:0] ad(int ch, int off);
    return ADDR_W'((ch << 13) | off);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int ch, int off, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ad(ch, off); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(int ch, int off, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ad(ch, off); bus_be = be;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 irq", 32'(irq), 0);
    chk("R2 state", 32'(ch_state[2:0]), 1);
    rd(0, 'h88, d); chk("R5 status reset", d, 32'h101);
    chk("R1 rvalid", 32'(bus_rvalid), 1);
    rd(2, 'h84, d); chk("R2 cfg", d, 0);
    rd(2, 'h8C, d); chk("R2 mask", d, 0);
    rd(1, 'h5C, d); chk("R2 ptr", d, 0);
  endtask

  task automatic t_ptrs();
    logic [31:0] d;
    wr(1, 'h00, 32'hA000_0001);
    wr(1, 'h58, 32'hB000_0002);
    wr(1, 'h5C, 32'hC000_0003);
    wr(1, 'h60, 32'hD000_0004);
    wr(1, 'h7C, 32'hE000_0005);
    rd(1, 'h00, d); chk("R1 dptr", d, 32'hA000_0001);
    rd(1, 'h58, d); chk("R1 sdata", d, 32'hB000_0002);
    rd(1, 'h5C, d); chk("R1 sbuf", d, 32'hC000_0003);
    rd(1, 'h60, d); chk("R1 grp", d, 32'hD000_0004);
    rd(1, 'h7C, d); chk("R1 gdown", d, 32'hE000_0005);
    rd(2, 'h58, d); chk("R12 other channel", d, 0);
    rd(0, 'h00, d); chk("R12 other channel", d, 0);
  endtask

  task automatic t_state();
    logic [31:0] d;
    @(negedge clk) eng_go[0] = 1'b1;
    @(negedge clk) eng_go[0] = 1'b0;
    chk("R4 go while disabled", 32'(ch_state[2:0]), 1);
    wr(0, 'h84, 32'h1);
    @(negedge clk) eng_go[0] = 1'b1;
    @(negedge clk) eng_go[0] = 1'b0;
    chk("R4 running", 32'(ch_state[2:0]), 4);
    eng_eol[0] = 1'b1; eng_src[7:0] = 8'h5A;
    rd(0, 'h88, d); chk("R5 status run", d, 32'h5A24);
    eng_eol[0] = 1'b0; eng_src[7:0] = 8'h01;
    wr(0, 'h84, 32'h3);
    chk("R3 stop", 32'(ch_state[2:0]), 2);
    rd(0, 'h88, d); chk("R5 status stop", d, 32'h102);
    wr(0, 'h84, 32'h2);
    chk("R3 disable wins", 32'(ch_state[2:0]), 1);
    wr(0, 'h84, 32'h1);
    // start and stopping config write in the same cycle
    @(negedge clk);
    eng_go[0] = 1'b1; bus_wr = 1'b1; bus_addr = ad(0, 'h84); bus_wdata = 32'h3;
    @(negedge clk);
    eng_go[0] = 1'b0; bus_wr = 1'b0;
    chk("R4 cfg write overrides go", 32'(ch_state[2:0]), 2);
    chk("R12 ch1 state", 32'(ch_state[5:3]), 1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(3, 'h8C, 32'h5);
    @(negedge clk) eng_irq_set[15:12] = 4'h3;
    @(negedge clk) eng_irq_set[15:12] = 4'h0;
    chk("R8 irq high", 32'(irq), 32'h8);
    rd(3, 'h94, d); chk("R8 raw", d, 3);
    rd(3, 'h98, d); chk("R8 masked", d, 1);
    wr(3, 'h90, 32'h1);
    chk("R6 irq after ack", 32'(irq), 0);
    rd(3, 'h94, d); chk("R6 raw after ack", d, 2);
    rd(3, 'h90, d); chk("R6 ack reads zero", d, 0);
    wr(3, 'h8C, 32'h2);
    chk("R8 mask write raises irq", 32'(irq), 32'h8);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ad(3, 'h90); bus_wdata = 32'h2;
    eng_irq_set[15:12] = 4'h2;
    @(negedge clk);
    bus_wr = 1'b0; eng_irq_set[15:12] = 4'h0;
    rd(3, 'h94, d); chk("R7 set beats ack", d, 2);
    chk("R7 irq kept", 32'(irq), 32'h8);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(2, 'h80, 32'hFF);
    chk("R9 cmd inval", 32'(bus_inval), 1);
    rd(2, 'h80, d); chk("R9 cmd bit0", d, 1);
    wr(2, 'h9C, 32'h12345);
    chk("R9 scmd inval", 32'(bus_inval), 1);
    rd(2, 'h9C, d); chk("R9 scmd low bits", d, 32'h345);
    wr(2, 'h9C, 32'h3FF);
    chk("R9 legal scmd", 32'(bus_inval), 0);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    wr(1, 'h00, 32'h1234_5678, 4'h3);
    chk("R10 write err", 32'(bus_err), 1);
    rd(1, 'h00, d); chk("R10 unchanged", d, 32'hA000_0001);
    chk("R10 full read no err", 32'(bus_err), 0);
    rd(1, 'h00, d, 4'h1); chk("R10 narrow read zero", d, 0);
    chk("R10 read err", 32'(bus_err), 1);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(3, 'h94, 32'hF);
    wr(3, 'h98, 32'hF);
    rd(3, 'h94, d); chk("R11 raw read-only", d, 2);
    rd(3, 'h98, d); chk("R11 masked read-only", d, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ptrs();
    t_state();
    t_irq();
    t_race();
    t_cmd();
    t_narrow();
    t_ro();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule